// File: doc/BRIEF.md
# Control Endpoint Mode/Status Register with Update Interlock

This block holds the control-endpoint state of a low-speed USB device. It sits between a CPU register bus and the serial interface engine. The state is a status/mode byte, a byte-count register and the device address register. The status/mode byte carries four event flags: setup seen, IN seen, OUT seen and handshake acknowledged. It also carries a 4-bit mode. The device address register holds a 7-bit address and an enable bit, and it produces the address-match signal the engine uses to accept tokens.

Firmware and the engine both write the status/mode and count registers. An interlock arbitrates between them. Any engine update locks out CPU writes to both registers. The lock stays until firmware reads the status/mode register, so a stale firmware write cannot overwrite an event it has not yet seen. An unlocked firmware write always clears the four flags. While a SETUP transaction is between its data phase and its acknowledge, the setup flag is held set. While that flag is set, CPU writes to the endpoint FIFO are gated off.

Top module: `ep0_ctrl_regs`

## Requirements
- R1: Hardware reset (`rst`) and USB bus reset (`bus_reset`) each clear the address register (enable included), the status/mode byte, the count register and the lock. A CPU write to the status/mode register right after a bus reset takes effect.
- R2: `addr_match` is 1 only while the address enable (bit 7 of the address register) is 1 and `tok_addr` equals address bits 6:0.
- R3: A CPU write to the status/mode register (select 1) that is not locked loads bits 3:0 from the data and clears bits 7:4, whatever the data bits 7:4 hold. Bit 7 is the exception while a setup window is open (R6).
- R4: Any engine strobe sets the lock. While the lock is set, CPU writes to the status/mode register and to the count register (select 2) leave them unchanged.
- R5: A CPU read of the status/mode register (`cpu_rd` with select 1) clears the lock at that clock edge. The next write then takes effect.
- R6: `eng_setup_start` sets bit 7 and opens the setup window. `eng_ack_start` closes it. While the window is open, a CPU write cannot clear bit 7. After the window closes, an unlocked write clears it.
- R7: `fifo_wr_en` equals `cpu_fifo_wr` while status bit 7 is 0, and it is 0 while bit 7 is 1.
- R8: `eng_in_rcvd`, `eng_out_rcvd` and `eng_acked` set status bits 6, 5 and 4 respectively.
- R9: When an engine strobe and a CPU write to the status/mode register fall in the same cycle, the engine update is applied, the write is dropped and the lock is set.
- R10: The count register holds `CNT_W` bits. A CPU write loads the low `CNT_W` data bits. `eng_count_ld` loads `eng_count` and locks. A read with select 2 returns the count zero-extended to 8 bits.
- R11: `cpu_rdata` is combinational from the registers. A read in the cycle after an engine update returns the updated value. Select 0 returns {enable, address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_reset | input | 1 | USB bus reset seen by the engine, synchronous |
| cpu_sel | input | 2 | Register select: 0 address, 1 status/mode, 2 count |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for the selected register |
| cpu_fifo_wr | input | 1 | CPU request to write the endpoint FIFO |
| fifo_wr_en | output | 1 | Gated FIFO write enable |
| eng_setup_start | input | 1 | Strobe: data phase of a SETUP transaction begins |
| eng_ack_start | input | 1 | Strobe: engine starts the handshake |
| eng_in_rcvd | input | 1 | Strobe: IN token received |
| eng_out_rcvd | input | 1 | Strobe: OUT token received |
| eng_acked | input | 1 | Strobe: transaction acknowledged |
| eng_mode_ld | input | 1 | Strobe: load mode from eng_mode |
| eng_mode | input | 4 | Mode value from the engine |
| eng_count_ld | input | 1 | Strobe: load count from eng_count |
| eng_count | input | CNT_W | Count value from the engine |
| tok_addr | input | ADDR_W | Address field of the incoming token |
| addr_match | output | 1 | Token address accepted |

## Verification
The bench builds the block with `ADDR_W` = 7 and `CNT_W` = 4.

With the full 7-bit address, the enable bit stays separate from the top address bit. That lets the bench show that a data byte of 0x05 with enable clear gives no match, while 0x85 does. With a 4-bit count, a write of 0xF6 must read back as 6, which exercises truncation of the write data.

Flag, lock and setup-window sequences are run with engine strobes and CPU writes placed in the same cycle and in adjacent cycles. This covers the collision rule, the read-to-unlock step and the bit-7 hold.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

    localparam int REG_W  = 8;
    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Bit order matches the register byte: 7 setup, 6 in, 5 out, 4 acked, 3:0 mode
    typedef struct packed {
        logic              setup;
        logic              in_rx;
        logic              out_rx;
        logic              acked;
        logic [MODE_W-1:0] mode;
    } ep0_stat_t;

    typedef struct packed {
        logic setup_start;
        logic ack_start;
        logic in_rx;
        logic out_rx;
        logic acked;
        logic mode_ld;
        logic count_ld;
    } eng_evt_t;

    function automatic logic evt_any(eng_evt_t e);
        return |e;
    endfunction

    // Status after an engine event
    function automatic ep0_stat_t apply_evt(ep0_stat_t cur, eng_evt_t e,
                                            logic [MODE_W-1:0] m);
        ep0_stat_t n;
        n = cur;
        if (e.setup_start) n.setup  = 1'b1;
        if (e.in_rx)       n.in_rx  = 1'b1;
        if (e.out_rx)      n.out_rx = 1'b1;
        if (e.acked)       n.acked  = 1'b1;
        if (e.mode_ld)     n.mode   = m;
        return n;
    endfunction

    // Status after an accepted CPU write: flags drop, setup held in its window
    function automatic ep0_stat_t apply_cpu_write(logic hold_setup,
                                                  logic [MODE_W-1:0] m);
        ep0_stat_t n;
        n.setup  = hold_setup;
        n.in_rx  = 1'b0;
        n.out_rx = 1'b0;
        n.acked  = 1'b0;
        n.mode   = m;
        return n;
    endfunction

endpackage

// File: rtl/ep0_addr_reg.sv
module ep0_addr_reg #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              wr_en,
    input  logic              wr_enable_bit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] tok_addr,
    output logic [ADDR_W-1:0] addr_q,
    output logic              en_q,
    output logic              match
);

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            addr_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            addr_q <= wr_addr;
            en_q   <= wr_enable_bit;
        end
    end

    always_comb begin
        match = en_q && (tok_addr == addr_q);
    end

endmodule

// File: rtl/ep0_lock_ctrl.sv
module ep0_lock_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic eng_update,
    input  logic unlock_rd,
    output logic lock_q
);

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            lock_q <= 1'b0;
        end else if (eng_update) begin
            lock_q <= 1'b1;
        end else if (unlock_rd) begin
            lock_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ep0_status_reg.sv
module ep0_status_reg
    import ep0_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  eng_evt_t          evt,
    input  logic [MODE_W-1:0] eng_mode,
    input  logic              wr_ok,
    input  logic [MODE_W-1:0] wr_mode,
    output ep0_stat_t         stat_q,
    output logic              window_q
);

    ep0_stat_t stat_d;
    logic      window_d;

    always_comb begin
        stat_d   = stat_q;
        window_d = window_q;
        if (evt_any(evt)) begin
            stat_d = apply_evt(stat_q, evt, eng_mode);
            if (evt.setup_start) begin
                window_d = 1'b1;
            end else if (evt.ack_start) begin
                window_d = 1'b0;
            end
        end else if (wr_ok) begin
            stat_d = apply_cpu_write(window_q, wr_mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            stat_q   <= '0;
            window_q <= 1'b0;
        end else begin
            stat_q   <= stat_d;
            window_q <= window_d;
        end
    end

endmodule

// File: rtl/ep0_count_reg.sv
module ep0_count_reg #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset,
    input  logic             eng_ld,
    input  logic [CNT_W-1:0] eng_val,
    input  logic             wr_ok,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            cnt_q <= '0;
        end else if (eng_ld) begin
            cnt_q <= eng_val;
        end else if (wr_ok) begin
            cnt_q <= wr_val;
        end
    end

endmodule

// File: rtl/ep0_ctrl_regs.sv
module ep0_ctrl_regs
    import ep0_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic [1:0]        cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              cpu_fifo_wr,
    output logic              fifo_wr_en,
    input  logic              eng_setup_start,
    input  logic              eng_ack_start,
    input  logic              eng_in_rcvd,
    input  logic              eng_out_rcvd,
    input  logic              eng_acked,
    input  logic              eng_mode_ld,
    input  logic [3:0]        eng_mode,
    input  logic              eng_count_ld,
    input  logic [CNT_W-1:0]  eng_count,
    input  logic [ADDR_W-1:0] tok_addr,
    output logic              addr_match
);

    localparam int ADDR_FIELD_W = REG_W - 1;

    reg_sel_e          sel;
    eng_evt_t          evt;
    logic              eng_any;
    logic              lock_q;
    logic              window_q;
    ep0_stat_t         stat_q;
    logic [ADDR_W-1:0] addr_q;
    logic              addr_en_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_addr_ok;
    logic              wr_mode_ok;
    logic              wr_cnt_ok;
    logic              rd_mode;

    always_comb begin
        sel              = reg_sel_e'(cpu_sel);
        evt.setup_start  = eng_setup_start;
        evt.ack_start    = eng_ack_start;
        evt.in_rx        = eng_in_rcvd;
        evt.out_rx       = eng_out_rcvd;
        evt.acked        = eng_acked;
        evt.mode_ld      = eng_mode_ld;
        evt.count_ld     = eng_count_ld;
        eng_any          = evt_any(evt);
        wr_addr_ok       = cpu_wr && (sel == SEL_ADDR);
        wr_mode_ok       = cpu_wr && (sel == SEL_MODE)  && !lock_q && !eng_any;
        wr_cnt_ok        = cpu_wr && (sel == SEL_COUNT) && !lock_q && !eng_any;
        rd_mode          = cpu_rd && (sel == SEL_MODE);
    end

    ep0_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk           (clk),
        .rst           (rst),
        .bus_reset     (bus_reset),
        .wr_en         (wr_addr_ok),
        .wr_enable_bit (cpu_wdata[REG_W-1]),
        .wr_addr       (cpu_wdata[ADDR_W-1:0]),
        .tok_addr      (tok_addr),
        .addr_q        (addr_q),
        .en_q          (addr_en_q),
        .match         (addr_match)
    );

    ep0_lock_ctrl u_lock (
        .clk        (clk),
        .rst        (rst),
        .bus_reset  (bus_reset),
        .eng_update (eng_any),
        .unlock_rd  (rd_mode),
        .lock_q     (lock_q)
    );

    ep0_status_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .evt       (evt),
        .eng_mode  (eng_mode),
        .wr_ok     (wr_mode_ok),
        .wr_mode   (cpu_wdata[MODE_W-1:0]),
        .stat_q    (stat_q),
        .window_q  (window_q)
    );

    ep0_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .eng_ld    (eng_count_ld),
        .eng_val   (eng_count),
        .wr_ok     (wr_cnt_ok),
        .wr_val    (cpu_wdata[CNT_W-1:0]),
        .cnt_q     (cnt_q)
    );

    always_comb begin
        unique case (sel)
            SEL_ADDR:  cpu_rdata = {addr_en_q, ADDR_FIELD_W'(addr_q)};
            SEL_MODE:  cpu_rdata = stat_q;
            SEL_COUNT: cpu_rdata = REG_W'(cnt_q);
            default:   cpu_rdata = '0;
        endcase
        fifo_wr_en = cpu_fifo_wr && !stat_q.setup;
    end

endmodule

// File: rtl/ep0_ctrl_checker.sv
module ep0_ctrl_checker
    import ep0_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_reset,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [1:0]        cpu_sel,
    input logic [MODE_W-1:0] wr_mode,
    input logic              eng_any,
    input logic              lock_q,
    input logic              window_q,
    input ep0_stat_t         stat_q,
    input logic              addr_en_q,
    input logic              addr_match,
    input logic              cpu_fifo_wr,
    input logic              fifo_wr_en
);

    logic mode_wr, mode_rd;
    always_comb begin
        mode_wr = cpu_wr && (cpu_sel == 2'(SEL_MODE));
        mode_rd = cpu_rd && (cpu_sel == 2'(SEL_MODE));
    end

    assert_bus_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (stat_q == '0 && !lock_q && !addr_en_q && !window_q));

    assert_match_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        addr_match |-> addr_en_q);

    assert_write_clears_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !lock_q && !eng_any && !bus_reset && !window_q)
        |=> (stat_q[7:4] == 4'b0 && stat_q.mode == $past(wr_mode)));

    assert_update_sets_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (eng_any && !bus_reset) |=> lock_q);

    assert_locked_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && lock_q && !eng_any && !bus_reset) |=> $stable(stat_q));

    assert_read_unlocks_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_rd && !eng_any) |=> !lock_q);

    assert_setup_held_R6: assert property (@(posedge clk) disable iff (rst)
        window_q |-> stat_q.setup);

    assert_fifo_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        stat_q.setup |-> !fifo_wr_en);

    assert_fifo_passes_R7: assert property (@(posedge clk) disable iff (rst)
        (!stat_q.setup && cpu_fifo_wr) |-> fifo_wr_en);

    assert_collision_engine_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && eng_any && !bus_reset) |=> lock_q);

endmodule

bind ep0_ctrl_regs ep0_ctrl_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_reset   (bus_reset),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .cpu_sel     (cpu_sel),
    .wr_mode     (cpu_wdata[3:0]),
    .eng_any     (eng_any),
    .lock_q      (lock_q),
    .window_q    (window_q),
    .stat_q      (stat_q),
    .addr_en_q   (addr_en_q),
    .addr_match  (addr_match),
    .cpu_fifo_wr (cpu_fifo_wr),
    .fifo_wr_en  (fifo_wr_en)
);

// File: tb/ep0_ctrl_regs_test.sv
module ep0_ctrl_regs_test;

    localparam int ADDR_W = 7;
    localparam int CNT_W  = 4;
    localparam logic [1:0] S_ADDR = 2'd0;
    localparam logic [1:0] S_MODE = 2'd1;
    localparam logic [1:0] S_CNT  = 2'd2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_reset = 1'b0;
    logic [1:0]        cpu_sel = '0;
    logic              cpu_wr = 1'b0;
    logic              cpu_rd = 1'b0;
    logic [7:0]        cpu_wdata = '0;
    logic [7:0]        cpu_rdata;
    logic              cpu_fifo_wr = 1'b0;
    logic              fifo_wr_en;
    logic              eng_setup_start = 1'b0;
    logic              eng_ack_start = 1'b0;
    logic              eng_in_rcvd = 1'b0;
    logic              eng_out_rcvd = 1'b0;
    logic              eng_acked = 1'b0;
    logic              eng_mode_ld = 1'b0;
    logic [3:0]        eng_mode = '0;
    logic              eng_count_ld = 1'b0;
    logic [CNT_W-1:0]  eng_count = '0;
    logic [ADDR_W-1:0] tok_addr = '0;
    logic              addr_match;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ep0_ctrl_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_fifo_wr(cpu_fifo_wr), .fifo_wr_en(fifo_wr_en),
        .eng_setup_start(eng_setup_start), .eng_ack_start(eng_ack_start),
        .eng_in_rcvd(eng_in_rcvd), .eng_out_rcvd(eng_out_rcvd),
        .eng_acked(eng_acked), .eng_mode_ld(eng_mode_ld), .eng_mode(eng_mode),
        .eng_count_ld(eng_count_ld), .eng_count(eng_count),
        .tok_addr(tok_addr), .addr_match(addr_match)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic peek(logic [1:0] s, output logic [7:0] d);
        cpu_sel = s;
        #1;
        d = cpu_rdata;
    endtask

    task automatic cpu_write(logic [1:0] s, logic [7:0] d);
        cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(logic [1:0] s, output logic [7:0] d);
        cpu_sel = s; cpu_rd = 1'b1;
        #1;
        d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic pulse_in();  eng_in_rcvd = 1'b1;  @(negedge clk); eng_in_rcvd = 1'b0;  endtask
    task automatic pulse_out(); eng_out_rcvd = 1'b1; @(negedge clk); eng_out_rcvd = 1'b0; endtask
    task automatic pulse_ack(); eng_acked = 1'b1;    @(negedge clk); eng_acked = 1'b0;    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(S_ADDR, d); chk("R1 addr after reset", d, 8'h00);
        peek(S_MODE, d); chk("R1 status after reset", d, 8'h00);
        peek(S_CNT, d);  chk("R1 count after reset", d, 8'h00);
        tok_addr = '0; #1;
        chk("R2 no match while disabled", 8'(addr_match), 8'h00);
    endtask

    task automatic t_address();
        logic [7:0] d;
        cpu_write(S_ADDR, 8'h85);
        peek(S_ADDR, d); chk("R11 addr readback", d, 8'h85);
        tok_addr = 7'd5; #1;
        chk("R2 match enabled equal", 8'(addr_match), 8'h01);
        tok_addr = 7'd6; #1;
        chk("R2 no match other addr", 8'(addr_match), 8'h00);
        cpu_write(S_ADDR, 8'h05);
        tok_addr = 7'd5; #1;
        chk("R2 no match when enable clear", 8'(addr_match), 8'h00);
    endtask

    task automatic t_flags_lock();
        logic [7:0] d;
        pulse_in();  peek(S_MODE, d); chk("R8 in flag bit6", d, 8'h40);
        pulse_out(); peek(S_MODE, d); chk("R8 out flag bit5", d, 8'h60);
        pulse_ack(); peek(S_MODE, d); chk("R8 acked flag bit4", d, 8'h70);
        cpu_write(S_MODE, 8'h03);
        peek(S_MODE, d); chk("R4 locked status write ignored", d, 8'h70);
        cpu_write(S_CNT, 8'h05);
        peek(S_CNT, d);  chk("R4 locked count write ignored", d, 8'h00);
        cpu_read(S_MODE, d); chk("R5 read returns status", d, 8'h70);
        cpu_write(S_MODE, 8'hF3);
        peek(S_MODE, d); chk("R3 write clears flags loads mode", d, 8'h03);
        cpu_write(S_CNT, 8'hF6);
        peek(S_CNT, d);  chk("R10 count write truncated", d, 8'h06);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        eng_in_rcvd = 1'b1;
        cpu_write(S_MODE, 8'h05);
        eng_in_rcvd = 1'b0;
        peek(S_MODE, d); chk("R9 engine wins collision", d, 8'h43);
        cpu_write(S_MODE, 8'h07);
        peek(S_MODE, d); chk("R9 lock set by collision", d, 8'h43);
        cpu_read(S_MODE, d);
        cpu_write(S_MODE, 8'h03);
        peek(S_MODE, d); chk("R5 write after unlock", d, 8'h03);
    endtask

    task automatic t_setup_window();
        logic [7:0] d;
        cpu_fifo_wr = 1'b1; #1;
        chk("R7 fifo write passes", 8'(fifo_wr_en), 8'h01);
        eng_setup_start = 1'b1; @(negedge clk); eng_setup_start = 1'b0;
        peek(S_MODE, d); chk("R6 setup flag set", d, 8'h83);
        chk("R7 fifo write blocked", 8'(fifo_wr_en), 8'h00);
        cpu_write(S_MODE, 8'h00);
        peek(S_MODE, d); chk("R4 locked during setup", d, 8'h83);
        cpu_read(S_MODE, d);
        cpu_write(S_MODE, 8'h01);
        peek(S_MODE, d); chk("R6 setup held in window", d, 8'h81);
        #1; chk("R7 fifo still blocked", 8'(fifo_wr_en), 8'h00);
        eng_ack_start = 1'b1; @(negedge clk); eng_ack_start = 1'b0;
        peek(S_MODE, d); chk("R6 ack keeps flag", d, 8'h81);
        cpu_read(S_MODE, d);
        cpu_write(S_MODE, 8'h02);
        peek(S_MODE, d); chk("R6 setup cleared after window", d, 8'h02);
        #1; chk("R7 fifo passes again", 8'(fifo_wr_en), 8'h01);
        cpu_fifo_wr = 1'b0;
    endtask

    task automatic t_engine_load();
        logic [7:0] d;
        eng_mode = 4'h9; eng_mode_ld = 1'b1;
        eng_count = 4'd7; eng_count_ld = 1'b1;
        @(negedge clk);
        eng_mode_ld = 1'b0; eng_count_ld = 1'b0;
        cpu_read(S_MODE, d); chk("R11 read sees engine mode", d, 8'h09);
        cpu_read(S_CNT, d);  chk("R10 engine count load", d, 8'h07);
    endtask

    task automatic t_bus_reset();
        logic [7:0] d;
        cpu_write(S_ADDR, 8'h8A);
        peek(S_ADDR, d); chk("R11 addr readback", d, 8'h8A);
        pulse_in();
        peek(S_MODE, d); chk("R8 in flag before bus reset", d, 8'h49);
        bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
        peek(S_ADDR, d); chk("R1 bus reset addr", d, 8'h00);
        peek(S_MODE, d); chk("R1 bus reset status", d, 8'h00);
        peek(S_CNT, d);  chk("R1 bus reset count", d, 8'h00);
        tok_addr = 7'h0A; #1;
        chk("R1 bus reset disables match", 8'(addr_match), 8'h00);
        cpu_write(S_MODE, 8'h04);
        peek(S_MODE, d); chk("R1 bus reset clears lock", d, 8'h04);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_address();
        t_flags_lock();
        t_collision();
        t_setup_window();
        t_engine_load();
        t_bus_reset();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule